// File: doc/BRIEF.md
# Sliding-Window Attention Step Sequencer

This block is the clocked controller for one head of an analog key/value attention store. A token step has five phases. The storage capacitors are discharged first. The new key and value column is then written while the query pulses drive the first dot product. Once both of those have finished, the value-side readout is cleared. Last, the first-stage pulses drive the second dot product. The analog arrays, converters and charge-to-pulse circuits sit outside the block. The controller sees them only as enables it drives and done flags it receives.

The controller also holds the position in the attention window. The window is a ring of columns spread over several equal sub-tiles. Every step writes the next column, so once the ring is full the oldest column is the one replaced. The write position appears on the ports as a one-hot sub-tile select and a column address. A step request that arrives during a step is remembered and starts the following step with no idle cycle.

Top module: `swa_step_seq`

## Requirements
- R1: While rst_ni is low, every phase enable, step_done_o and tile_sel_o are 0 and col_o is 0. The first step after reset writes window position 0.
- R2: A step_req_i sampled high while idle starts the step on the next cycle. dis_en_o is then high for exactly DIS_CYC (default 5) cycles, and no other phase enable is high during that time.
- R3: wr_en_o rises in the cycle right after the discharge ends and stays high for exactly WR_CYC (default 10) cycles.
- R4: q_en_o rises in the same cycle as wr_en_o. It falls after QRY_CYC (default 15) cycles, or at the end of the first cycle in which qry_done_i is sampled high, whichever comes first.
- R5: ro_rst_o is high for exactly ROR_CYC (default 2) cycles. It starts in the cycle after both the write and the query have ended, and it never overlaps any other phase enable.
- R6: v_en_o rises right after ro_rst_o falls. It lasts DOT2_CYC (default 42) cycles, or ends at the end of the first cycle in which dot2_done_i is sampled high.
- R7: step_done_o is a single-cycle pulse in the cycle after v_en_o falls. With no early done flags, a step lasts 65 cycles from the first discharge cycle to step_done_o inclusive.
- R8: The window position is a binary index. Bits [9:6] select the sub-tile and bits [5:0] give the column. During write, tile_sel_o has exactly the bit for that sub-tile set and col_o holds the column. tile_sel_o is all zero outside write. The index advances by one per completed step.
- R9: After position N_TILE*TILE_COLS-1 (default 1023), the next step writes position 0 (sub-tile 0, column 0).
- R10: One or more step_req_i pulses during a busy step are stored as a single pending request. The next step's discharge then starts in the cycle right after step_done_o.
- R11: After step_done_o with no request stored or present, all phase enables stay low until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_req_i | input | 1 | Request for one attention step |
| qry_done_i | input | 1 | First dot product finished early |
| dot2_done_i | input | 1 | Second dot product finished early |
| dis_en_o | output | 1 | Capacitor discharge phase |
| wr_en_o | output | 1 | Key/value column write phase |
| q_en_o | output | 1 | Query pulse phase |
| ro_rst_o | output | 1 | Value-side readout reset |
| v_en_o | output | 1 | Second dot product phase |
| tile_sel_o | output | N_TILE | One-hot sub-tile select during write |
| col_o | output | log2(TILE_COLS) | Column address within the sub-tile |
| step_done_o | output | 1 | One-cycle end-of-step pulse |

## Verification
A bad phase counter shows up in the same step, as an enable that is too long or too short, and the end-of-step pulse moves by the same amount. The bench measures the start cycle and the length of every enable against figures computed from the early-done cycles it drove. A wrong window index shows up at the very next write as a wrong sub-tile bit or column, and the wrap is checked by running the index through the full ring. A lost or duplicated pending request shows up within one cycle after step_done_o: either no discharge starts, or an extra step runs when the block should be idle.

// File: rtl/swa_seq_pkg.sv
package swa_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIS,
    ST_OVL,
    ST_ROR,
    ST_DOT2,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/swa_ph_timer.sv
// Phase window: busy for LEN cycles after start, or until abort while busy.
module swa_ph_timer #(
  parameter int LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic end_o
);
  localparam int CW = $clog2(LEN + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign end_o  = busy_q & (abort_i | (cnt_q == CW'(LEN - 1)));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (end_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/swa_win_addr.sv
module swa_win_addr #(
  parameter int N_TILE    = 16,
  parameter int TILE_COLS = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         adv_i,
  input  logic                         wr_en_i,
  output logic [N_TILE-1:0]            tile_sel_o,
  output logic [$clog2(TILE_COLS)-1:0] col_o
);
  localparam int COL_W  = $clog2(TILE_COLS);
  localparam int TILE_W = $clog2(N_TILE);
  localparam int IDX_W  = COL_W + TILE_W;
  localparam int WIN    = N_TILE * TILE_COLS;

  logic [IDX_W-1:0]  idx_q;
  logic [TILE_W-1:0] tile_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (adv_i) idx_q <= (idx_q == IDX_W'(WIN - 1)) ? '0 : idx_q + IDX_W'(1);
  end

  assign tile_idx = idx_q[IDX_W-1:COL_W];
  assign col_o    = idx_q[COL_W-1:0];

  for (genvar g = 0; g < N_TILE; g++) begin : g_tile
    assign tile_sel_o[g] = wr_en_i & (tile_idx == TILE_W'(g));
  end
endmodule

// File: rtl/swa_step_ctrl.sv
module swa_step_ctrl
  import swa_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_req_i,
  input  logic dis_end_i,
  input  logic wr_busy_i,
  input  logic wr_end_i,
  input  logic q_busy_i,
  input  logic q_end_i,
  input  logic ror_end_i,
  input  logic d2_end_i,
  output logic dis_start_o,
  output logic ovl_start_o,
  output logic ror_start_o,
  output logic d2_start_o,
  output logic step_done_o
);
  seq_st_e st_q, st_d;
  logic    pend_q, pend_d;
  logic    go, wr_fin, q_fin;

  assign go     = step_req_i | pend_q;
  assign wr_fin = ~wr_busy_i | wr_end_i;
  assign q_fin  = ~q_busy_i | q_end_i;

  always_comb begin
    st_d        = st_q;
    pend_d      = pend_q | step_req_i;
    dis_start_o = 1'b0;
    ovl_start_o = 1'b0;
    ror_start_o = 1'b0;
    d2_start_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (go) begin
          st_d        = ST_DIS;
          dis_start_o = 1'b1;
        end
      end
      ST_DIS: if (dis_end_i) begin
        st_d        = ST_OVL;
        ovl_start_o = 1'b1;
      end
      // write and query run together; leave when both are over
      ST_OVL: if (wr_fin && q_fin) begin
        st_d        = ST_ROR;
        ror_start_o = 1'b1;
      end
      ST_ROR: if (ror_end_i) begin
        st_d       = ST_DOT2;
        d2_start_o = 1'b1;
      end
      ST_DOT2: if (d2_end_i) st_d = ST_DONE;
      ST_DONE: begin
        pend_d = 1'b0;
        if (go) begin
          st_d        = ST_DIS;
          dis_start_o = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
    end
  end

  assign step_done_o = (st_q == ST_DONE);
endmodule

// File: rtl/swa_step_seq.sv
module swa_step_seq #(
  parameter int DIS_CYC   = 5,
  parameter int WR_CYC    = 10,
  parameter int QRY_CYC   = 15,
  parameter int ROR_CYC   = 2,
  parameter int DOT2_CYC  = 42,
  parameter int N_TILE    = 16,
  parameter int TILE_COLS = 64,
  localparam int COL_W    = $clog2(TILE_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_req_i,
  input  logic              qry_done_i,
  input  logic              dot2_done_i,
  output logic              dis_en_o,
  output logic              wr_en_o,
  output logic              q_en_o,
  output logic              ro_rst_o,
  output logic              v_en_o,
  output logic [N_TILE-1:0] tile_sel_o,
  output logic [COL_W-1:0]  col_o,
  output logic              step_done_o
);
  logic dis_start, ovl_start, ror_start, d2_start;
  logic dis_busy, dis_end, wr_busy, wr_end, q_busy, q_end;
  logic ror_busy, ror_end, d2_busy, d2_end;

  swa_step_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_req_i  (step_req_i),
    .dis_end_i   (dis_end),
    .wr_busy_i   (wr_busy),
    .wr_end_i    (wr_end),
    .q_busy_i    (q_busy),
    .q_end_i     (q_end),
    .ror_end_i   (ror_end),
    .d2_end_i    (d2_end),
    .dis_start_o (dis_start),
    .ovl_start_o (ovl_start),
    .ror_start_o (ror_start),
    .d2_start_o  (d2_start),
    .step_done_o (step_done_o)
  );

  swa_ph_timer #(.LEN(DIS_CYC)) u_dis_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(dis_start), .abort_i(1'b0),
    .busy_o(dis_busy), .end_o(dis_end));

  swa_ph_timer #(.LEN(WR_CYC)) u_wr_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ovl_start), .abort_i(1'b0),
    .busy_o(wr_busy), .end_o(wr_end));

  swa_ph_timer #(.LEN(QRY_CYC)) u_q_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ovl_start), .abort_i(qry_done_i),
    .busy_o(q_busy), .end_o(q_end));

  swa_ph_timer #(.LEN(ROR_CYC)) u_ror_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(ror_start), .abort_i(1'b0),
    .busy_o(ror_busy), .end_o(ror_end));

  swa_ph_timer #(.LEN(DOT2_CYC)) u_d2_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(d2_start), .abort_i(dot2_done_i),
    .busy_o(d2_busy), .end_o(d2_end));

  swa_win_addr #(.N_TILE(N_TILE), .TILE_COLS(TILE_COLS)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (step_done_o),
    .wr_en_i    (wr_busy),
    .tile_sel_o (tile_sel_o),
    .col_o      (col_o)
  );

  assign dis_en_o = dis_busy;
  assign wr_en_o  = wr_busy;
  assign q_en_o   = q_busy;
  assign ro_rst_o = ror_busy;
  assign v_en_o   = d2_busy;
endmodule

// File: rtl/swa_step_seq_chk.sv
module swa_step_seq_chk #(
  parameter int N_TILE = 16,
  parameter int COL_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dis_en_o,
  input logic              wr_en_o,
  input logic              q_en_o,
  input logic              ro_rst_o,
  input logic              v_en_o,
  input logic [N_TILE-1:0] tile_sel_o,
  input logic [COL_W-1:0]  col_o,
  input logic              step_done_o
);
  p_dis_alone_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_en_o |-> !(wr_en_o || q_en_o || ro_rst_o || v_en_o));

  p_wr_q_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $rose(q_en_o));

  p_ror_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_rst_o |-> !(dis_en_o || wr_en_o || q_en_o || v_en_o));

  p_v_after_ror_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ro_rst_o) |-> v_en_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |=> !step_done_o);

  p_done_after_v_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_done_o |-> (!v_en_o && $past(v_en_o)));

  p_tile_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o ? ($countones(tile_sel_o) == 1) : (tile_sel_o == '0));

  p_col_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> ($stable(col_o) && $stable(tile_sel_o)));
endmodule

bind swa_step_seq swa_step_seq_chk #(.N_TILE(N_TILE), .COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dis_en_o    (dis_en_o),
  .wr_en_o     (wr_en_o),
  .q_en_o      (q_en_o),
  .ro_rst_o    (ro_rst_o),
  .v_en_o      (v_en_o),
  .tile_sel_o  (tile_sel_o),
  .col_o       (col_o),
  .step_done_o (step_done_o)
);

// File: tb/swa_step_seq_tb.sv
module swa_step_seq_tb_top;
  localparam int DIS = 5;
  localparam int WR  = 10;
  localparam int QRY = 15;
  localparam int ROR = 2;
  localparam int D2  = 42;
  localparam int NT  = 16;
  localparam int TC  = 64;
  localparam int WIN = NT * TC;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          step_req = 1'b0;
  logic          qry_done = 1'b0;
  logic          dot2_done = 1'b0;
  logic          dis_en, wr_en, q_en, ro_rst, v_en, step_done;
  logic [NT-1:0] tile_sel;
  logic [5:0]    col;

  int n_chk = 0;
  int n_err = 0;
  int exp_idx = 0;
  bit wrapped = 1'b0;

  always #5 clk = ~clk;

  swa_step_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .step_req_i(step_req),
    .qry_done_i(qry_done), .dot2_done_i(dot2_done),
    .dis_en_o(dis_en), .wr_en_o(wr_en), .q_en_o(q_en), .ro_rst_o(ro_rst),
    .v_en_o(v_en), .tile_sel_o(tile_sel), .col_o(col), .step_done_o(step_done));

  function automatic int f_qlen(input int qe);
    return (qe == 0) ? QRY : qe;
  endfunction
  function automatic int f_d2len(input int de);
    return (de == 0) ? D2 : de;
  endfunction
  function automatic int f_ovl_end(input int qe);
    return DIS + ((f_qlen(qe) > WR) ? f_qlen(qe) : WR);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // One step. qe/de: early-done cycle within query / dot2 (0 = none).
  // extra: raise requests mid-step. pre: step already pending, do not request.
  task automatic run_step(input int qe, input int de, input bit extra, input bit pre);
    int dis_n = 0, dis_f = -1, wr_n = 0, wr_f = -1, q_n = 0, q_f = -1;
    int ro_n = 0, ro_f = -1, v_n = 0, v_f = -1, done_r = -1;
    int tile_bad = 0, col_bad = 0, vs;
    logic [NT-1:0] exp_tile;
    vs = f_ovl_end(qe) + ROR;
    exp_tile = NT'(1) << (exp_idx / TC);
    if (!pre) step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    for (int r = 0; r < 300; r++) begin
      if (dis_en) begin dis_n++; if (dis_f < 0) dis_f = r; end
      if (wr_en)  begin wr_n++;  if (wr_f < 0)  wr_f = r;  end
      if (q_en)   begin q_n++;   if (q_f < 0)   q_f = r;   end
      if (ro_rst) begin ro_n++;  if (ro_f < 0)  ro_f = r;  end
      if (v_en)   begin v_n++;   if (v_f < 0)   v_f = r;   end
      if (wr_en) begin
        if (tile_sel !== exp_tile) tile_bad++;
        if (int'(col) != exp_idx % TC) col_bad++;
      end else if (tile_sel !== '0) tile_bad++;
      if (step_done) begin done_r = r; break; end
      qry_done  = (qe != 0) && (r == DIS + qe - 1);
      dot2_done = (de != 0) && (r == vs + de - 1);
      step_req  = extra && (r == 3 || r == 20);
      @(negedge clk);
    end
    qry_done = 1'b0; dot2_done = 1'b0; step_req = 1'b0;
    chk(dis_f == 0, pre ? "R10 back-to-back start" : "R2 discharge start", dis_f, 0);
    chk(dis_n == DIS, "R2 discharge length", dis_n, DIS);
    chk(wr_f == DIS, "R3 write start", wr_f, DIS);
    chk(wr_n == WR, "R3 write length", wr_n, WR);
    chk(q_f == DIS, "R4 query start", q_f, DIS);
    chk(q_n == f_qlen(qe), "R4 query length", q_n, f_qlen(qe));
    chk(ro_f == f_ovl_end(qe), "R5 readout reset start", ro_f, f_ovl_end(qe));
    chk(ro_n == ROR, "R5 readout reset length", ro_n, ROR);
    chk(v_f == vs, "R6 dot2 start", v_f, vs);
    chk(v_n == f_d2len(de), "R6 dot2 length", v_n, f_d2len(de));
    chk(done_r == vs + f_d2len(de), "R7 step_done cycle", done_r, vs + f_d2len(de));
    chk(tile_bad == 0, "R8 tile select", tile_bad, 0);
    if (wrapped && exp_idx == 0) chk(col_bad == 0, "R9 wrap to position 0", col_bad, 0);
    else chk(col_bad == 0, "R8 column address", col_bad, 0);
    exp_idx = (exp_idx + 1) % WIN;
    if (exp_idx == 0) wrapped = 1'b1;
  endtask

  task automatic idle_check(input int n);
    int act = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dis_en || wr_en || q_en || ro_rst || v_en || step_done) act++;
    end
    chk(act == 0, "R11 stays idle", act, 0);
  endtask

  initial begin
    #(190000 * 10);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_a77e));
    #1;
    chk({dis_en, wr_en, q_en, ro_rst, v_en, step_done} == '0, "R1 enables in reset",
        {dis_en, wr_en, q_en, ro_rst, v_en, step_done}, 0);
    chk(tile_sel == '0 && col == '0, "R1 address in reset", int'(col), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    idle_check(4);

    run_step(0, 0, 0, 0);   // nominal 65-cycle step
    run_step(4, 0, 0, 0);   // query ends before write
    run_step(12, 0, 0, 0);  // query ends after write
    run_step(0, 7, 0, 0);   // dot2 early
    run_step(1, 1, 0, 0);   // shortest
    run_step(QRY, D2, 0, 0);

    run_step(0, 0, 1, 0);   // R10: two mid-step requests collapse to one
    run_step(0, 0, 0, 1);
    idle_check(10);

    for (int i = 0; i < 40; i++) begin
      run_step(int'($urandom_range(0, QRY)), int'($urandom_range(0, D2)), 1'b0, 1'b0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    while (exp_idx != WIN - 1) run_step(1, 1, 0, 0);
    run_step(2, 3, 0, 0);   // last position
    run_step(5, 9, 0, 0);   // R9: wrapped to 0
    run_step(0, 0, 0, 0);

    // asynchronous reset mid-step
    step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    repeat (12) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk({dis_en, wr_en, q_en, ro_rst, v_en, step_done} == '0, "R1 enables after reset",
        {dis_en, wr_en, q_en, ro_rst, v_en, step_done}, 0);
    chk(col == '0, "R1 column after reset", int'(col), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    exp_idx = 0;
    wrapped = 1'b0;
    @(negedge clk);
    run_step(0, 0, 0, 0);   // R1: first step after reset writes position 0
    idle_check(5);

    summary();
  end
endmodule